// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block sits on the controller side of a four-bank DDR SDRAM. It times the average refresh interval in clock cycles and keeps a credit of refreshes that are owed. It asks the command arbiter for the bus whenever the credit is non-zero. Once the arbiter grants the bus and every bank reports precharged, it drives the auto-refresh command. After each refresh it holds off all other commands for the refresh recovery time. Up to `MAX_OWED` refreshes may be postponed. When the credit reaches that cap, the request is flagged urgent so the arbiter serves it ahead of everything else.

On request the block also places the device in self refresh. While the request stays high, CKE stays low and the bus carries only NOP. When the request drops, the block raises CKE under a NOP. It then reports two separate hold-offs: one for non-read commands and a longer one for reads. The owed credit is cleared on entry to self refresh, because the device refreshes itself during that time. The interval timer starts again from zero at exit. Precharging open banks is left to the rest of the controller; this block only waits for them to be idle.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `cmd` is NOP (4'b0111, bit order {cs_n, ras_n, cas_n, we_n}), `cke` is 1, and `arb_req`, `arb_urgent`, `hold_cmd` and `hold_read` are all 0.
- R2: The owed credit grows by one every `T_REFI` cycles, so `arb_req` first rises exactly `T_REFI` cycles after reset is released.
- R3: The credit saturates at `MAX_OWED`, and intervals that end at the cap are lost. `arb_urgent` is high exactly when the credit equals `MAX_OWED`, and granting the bus then yields exactly `MAX_OWED` refreshes.
- R4: When an interval ends in the same cycle that a refresh is issued, the credit does not change.
- R5: A refresh or self-refresh entry is driven only in the cycle after one in which `arb_gnt` and `banks_idle` were both high. While `banks_idle` is low, no refresh is driven.
- R6: Auto refresh is driven as `cmd` = 4'b0001 with `cke` held high.
- R7: `hold_cmd` is high for exactly `T_RFC` cycles, starting with the cycle that carries a refresh. Owed refreshes issue back to back exactly `T_RFC` cycles apart.
- R8: When the credit is at the cap, a pending refresh is issued before a self-refresh entry. Below the cap, a self-refresh request takes the bus first.
- R9: Self-refresh entry is `cmd` = 4'b0001 with `cke` going low. While in self refresh, `cmd` stays NOP, `cke` stays low, `hold_cmd` is high and `arb_req` is low. Entry clears the owed credit.
- R10: One cycle after `sr_req` falls, `cke` is high with `cmd` NOP. `hold_cmd` then stays high for `T_XSNR` cycles and `hold_read` for `T_XSRD` cycles, both counted from that cycle.
- R11: The interval timer restarts at self-refresh exit, so `arb_req` next rises exactly `T_REFI` cycles after the exit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle | input | 1 | All four banks are precharged |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| arb_gnt | input | 1 | Arbiter grants the command bus this cycle |
| arb_req | output | 1 | Request for the command bus |
| arb_urgent | output | 1 | Credit at the cap; serve before any other command |
| cmd | output | 4 | Command lines {cs_n, ras_n, cas_n, we_n} |
| cke | output | 1 | Clock enable to the device |
| hold_cmd | output | 1 | No other command may be issued this cycle |
| hold_read | output | 1 | No read command may be issued this cycle |

## Verification
The embedded assertions check several properties on every cycle:
- the credit never passes its cap;
- a coinciding interval end and issue leaves the credit unchanged;
- a refresh never follows a cycle without idle banks;
- a refresh is always followed by NOP;
- CKE rises only under NOP;
- the bus stays quiet while CKE is low;
- the read hold-off never ends before the general one.

Only the bench scenarios can show the exact cycle counts:
- the interval length;
- the number of refreshes drained after several postponed intervals, including intervals lost at the cap;
- the spacing of back-to-back refreshes;
- the priority of an urgent refresh over self-refresh entry;
- the lengths of the two exit hold-offs;
- the timer restart after exit.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  // command lines ordered {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_AREF = 4'b0001,
    CMD_NOP  = 4'b0111
  } dram_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECOV = 2'd1,
    ST_SELF  = 2'd2
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refsch_interval.sv
module refsch_interval #(
  parameter int unsigned T_REFI = 1040
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (T_REFI > 2) ? $clog2(T_REFI) : 1;
  localparam logic [CW-1:0] LAST = CW'(T_REFI - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = !clr && (cnt == LAST);

  // R11
  interval_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

endmodule

// File: rtl/refsch_credit.sv
module refsch_credit #(
  parameter int unsigned MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic pending,
  output logic urgent
);
  localparam int unsigned OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] CAP = OW'(MAX_OWED);

  logic [OW-1:0] owed;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      owed <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (owed != CAP) owed <= owed + 1'b1;
        2'b01:   if (owed != '0)  owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assign pending = (owed != '0);
  assign urgent  = (owed == CAP);

  // R3
  credit_cap_chk: assert property (@(posedge clk) disable iff (rst)
    owed <= CAP);

  // R3
  credit_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && !clr && urgent) |=> urgent);

  // R4
  credit_balance_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && dec && !clr) |=> (owed == $past(owed)));

endmodule

// File: rtl/refsch_seq.sv
module refsch_seq
  import refsch_pkg::*;
#(
  parameter int unsigned T_RFC  = 10,
  parameter int unsigned T_XSNR = 10,
  parameter int unsigned T_XSRD = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic urgent,
  input  logic sr_req,
  input  logic arb_gnt,
  input  logic banks_idle,
  output logic issue_ref,
  output logic sr_clr,
  output logic arb_req,
  output logic [3:0] cmd,
  output logic cke,
  output logic hold_cmd,
  output logic hold_read
);
  localparam int unsigned RCW = $clog2(max2(max2(T_RFC, T_XSNR), 2));
  localparam int unsigned XCW = $clog2(max2(T_XSRD, 2));

  seq_state_e     state;
  logic [RCW-1:0] rcnt;
  logic [XCW-1:0] rd_cnt;
  logic           rd_busy;
  dram_cmd_e      cmd_q;
  logic           cke_q;
  logic           can_go;
  logic           enter_sr;

  assign can_go    = ((state == ST_IDLE) || ((state == ST_RECOV) && (rcnt == '0)))
                     && arb_gnt && banks_idle;
  assign issue_ref = can_go && pending && (urgent || !sr_req);
  assign enter_sr  = can_go && sr_req && !issue_ref;
  assign sr_clr    = enter_sr || (state == ST_SELF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      rcnt    <= '0;
      rd_cnt  <= '0;
      rd_busy <= 1'b0;
      cmd_q   <= CMD_NOP;
      cke_q   <= 1'b1;
    end else begin
      cmd_q <= CMD_NOP;
      if (rd_busy) begin
        if (rd_cnt == '0) rd_busy <= 1'b0;
        else              rd_cnt  <= rd_cnt - 1'b1;
      end
      if (issue_ref) begin
        cmd_q <= CMD_AREF;
        state <= ST_RECOV;
        rcnt  <= RCW'(T_RFC - 1);
      end else if (enter_sr) begin
        cmd_q <= CMD_AREF;
        cke_q <= 1'b0;
        state <= ST_SELF;
      end else begin
        unique case (state)
          ST_RECOV: begin
            if (rcnt == '0) state <= ST_IDLE;
            else            rcnt  <= rcnt - 1'b1;
          end
          ST_SELF: begin
            if (!sr_req) begin
              cke_q   <= 1'b1;
              state   <= ST_RECOV;
              rcnt    <= RCW'(T_XSNR - 1);
              rd_busy <= 1'b1;
              rd_cnt  <= XCW'(T_XSRD - 1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign arb_req   = (state != ST_SELF) && (pending || sr_req);
  assign cmd       = cmd_q;
  assign cke       = cke_q;
  assign hold_cmd  = (state != ST_IDLE);
  assign hold_read = hold_cmd || rd_busy;

  // R5
  aref_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_AREF) |-> ($past(banks_idle) && $past(arb_gnt)));

  // R7
  aref_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_AREF && cke_q) |=> (cmd_q == CMD_NOP));

  // R10
  cke_exit_nop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_q) |-> (cmd_q == CMD_NOP));

  // R9
  self_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cke_q && $past(!cke_q)) |-> (cmd_q == CMD_NOP && !arb_req));

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
  parameter int unsigned T_REFI   = 1040,
  parameter int unsigned MAX_OWED = 8,
  parameter int unsigned T_RFC    = 10,
  parameter int unsigned T_XSNR   = 10,
  parameter int unsigned T_XSRD   = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       banks_idle,
  input  logic       sr_req,
  input  logic       arb_gnt,
  output logic       arb_req,
  output logic       arb_urgent,
  output logic [3:0] cmd,
  output logic       cke,
  output logic       hold_cmd,
  output logic       hold_read
);
  logic tick;
  logic pending;
  logic urgent;
  logic issue_ref;
  logic sr_clr;

  refsch_interval #(.T_REFI(T_REFI)) u_interval (
    .clk  (clk),
    .rst  (rst),
    .clr  (sr_clr),
    .tick (tick)
  );

  refsch_credit #(.MAX_OWED(MAX_OWED)) u_credit (
    .clk     (clk),
    .rst     (rst),
    .clr     (sr_clr),
    .inc     (tick),
    .dec     (issue_ref),
    .pending (pending),
    .urgent  (urgent)
  );

  refsch_seq #(.T_RFC(T_RFC), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .pending    (pending),
    .urgent     (urgent),
    .sr_req     (sr_req),
    .arb_gnt    (arb_gnt),
    .banks_idle (banks_idle),
    .issue_ref  (issue_ref),
    .sr_clr     (sr_clr),
    .arb_req    (arb_req),
    .cmd        (cmd),
    .cke        (cke),
    .hold_cmd   (hold_cmd),
    .hold_read  (hold_read)
  );

  assign arb_urgent = urgent;

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_read) |-> !hold_cmd);

endmodule

// File: tb/tb_refresh_scheduler.sv
module tb_refresh_scheduler;
  localparam int CLK_PERIOD = 10;
  localparam int T_REFI = 100;
  localparam int MAXO   = 8;
  localparam int T_RFC  = 5;
  localparam int T_XSNR = 6;
  localparam int T_XSRD = 30;
  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] AREF = 4'b0001;

  // {intervals waited, expected urgent, expected refreshes drained}
  localparam int VEC [5][3] = '{
    '{1, 0, 1}, '{3, 0, 3}, '{7, 0, 7}, '{8, 1, 8}, '{10, 1, 8}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic banks_idle = 1'b1;
  logic sr_req = 1'b0;
  logic arb_gnt = 1'b0;
  logic arb_req, arb_urgent, cke, hold_cmd, hold_read;
  logic [3:0] cmd;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_scheduler #(
    .T_REFI(T_REFI), .MAX_OWED(MAXO), .T_RFC(T_RFC), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)
  ) dut (
    .clk(clk), .rst(rst), .banks_idle(banks_idle), .sr_req(sr_req), .arb_gnt(arb_gnt),
    .arb_req(arb_req), .arb_urgent(arb_urgent), .cmd(cmd), .cke(cke),
    .hold_cmd(hold_cmd), .hold_read(hold_read)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; sr_req = 1'b0; arb_gnt = 1'b0; banks_idle = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    int last;
    int mingap;
    @(negedge clk);

    // credit table walk: R3, R6, R7
    for (int v = 0; v < 5; v++) begin
      do_reset();
      step(VEC[v][0] * T_REFI);
      chk("R3 urgent flag", arb_urgent, VEC[v][1]);
      arb_gnt = 1'b1;
      cnt = 0; last = -1; mingap = 1000;
      for (int i = 0; i < 60; i++) begin
        step(1);
        if (cmd == AREF && cke) begin
          cnt++;
          if (last >= 0 && (i - last) < mingap) mingap = i - last;
          last = i;
        end
      end
      arb_gnt = 1'b0;
      chk("R3 refreshes drained", cnt, VEC[v][2]);
      if (VEC[v][2] > 1) chk("R7 back-to-back spacing", mingap, T_RFC);
      chk("R3 credit empty after drain", arb_req, 0);
    end

    // R1 reset state
    rst = 1'b1;
    step(2);
    chk("R1 cmd during reset", cmd, NOP);
    rst = 1'b0;
    step(1);
    chk("R1 cmd", cmd, NOP);
    chk("R1 cke", cke, 1);
    chk("R1 arb_req", arb_req, 0);
    chk("R1 arb_urgent", arb_urgent, 0);
    chk("R1 hold_cmd", hold_cmd, 0);
    chk("R1 hold_read", hold_read, 0);

    // R2 interval length
    do_reset();
    step(T_REFI - 1);
    chk("R2 no request before interval", arb_req, 0);
    step(1);
    chk("R2 request at interval", arb_req, 1);

    // R5 banks busy blocks refresh
    banks_idle = 1'b0; arb_gnt = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (cmd != NOP) cnt++;
    end
    chk("R5 no command while banks busy", cnt, 0);
    banks_idle = 1'b1;
    step(1);
    chk("R6 auto refresh encoding", cmd, AREF);
    chk("R6 cke high on refresh", cke, 1);
    arb_gnt = 1'b0;
    step(T_RFC - 1);
    chk("R7 hold at last recovery cycle", hold_cmd, 1);
    step(1);
    chk("R7 hold released", hold_cmd, 0);

    // R4 interval end coincides with issue
    do_reset();
    step(2 * T_REFI - 1);
    arb_gnt = 1'b1;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (cmd == AREF) cnt++;
    end
    arb_gnt = 1'b0;
    chk("R4 net-zero credit yields two refreshes", cnt, 2);

    // R8 urgent before self refresh, then R9 entry
    do_reset();
    step(MAXO * T_REFI);
    chk("R8 urgent before entry", arb_urgent, 1);
    sr_req = 1'b1; arb_gnt = 1'b1;
    step(1);
    chk("R8 urgent refresh first cmd", cmd, AREF);
    chk("R8 urgent refresh keeps cke", cke, 1);
    step(T_RFC);
    chk("R9 entry cmd", cmd, AREF);
    chk("R9 entry cke low", cke, 0);
    step(1);
    chk("R9 nop in self refresh", cmd, NOP);
    chk("R9 no request in self refresh", arb_req, 0);
    cnt = 0;
    for (int i = 0; i < 2 * T_REFI; i++) begin
      step(1);
      if (cmd != NOP || cke || arb_req || !hold_cmd) cnt++;
    end
    chk("R9 quiet during long self refresh", cnt, 0);
    arb_gnt = 1'b0;

    // R10 exit, R11 timer restart
    sr_req = 1'b0;
    step(1);
    chk("R10 cke high at exit", cke, 1);
    chk("R10 nop at exit", cmd, NOP);
    chk("R9 credit cleared", arb_req, 0);
    step(T_XSNR - 1);
    chk("R10 non-read hold last cycle", hold_cmd, 1);
    step(1);
    chk("R10 non-read hold released", hold_cmd, 0);
    chk("R10 read hold continues", hold_read, 1);
    step(T_XSRD - T_XSNR - 1);
    chk("R10 read hold last cycle", hold_read, 1);
    step(1);
    chk("R10 read hold released", hold_read, 0);
    step(T_REFI - T_XSRD - 1);
    chk("R11 no request before restarted interval", arb_req, 0);
    step(1);
    chk("R11 request at restarted interval", arb_req, 1);

    finish_run();
  end

endmodule